// File: doc/BRIEF.md
# DRAM Refresh and DMA Bus-Hold Arbiter

This block keeps a 128-row dynamic RAM refreshed by borrowing the processor bus through its single bus-hold request. The same request also serves an external DMA requester. A free-running interval timer counts processor clock cycles. Each time it expires, one refresh is queued in distributed mode, or a full set of 128 row refreshes is queued in burst mode. The arbiter raises the hold request and waits for the processor's acknowledge. It then emits one refresh strobe together with the row address for each granted refresh, and the row counter advances after each strobe.

Refresh and DMA take turns when both are waiting. A DMA tenure is cut short as soon as a second refresh becomes outstanding, so DMA cannot starve refresh. The timer runs without regard to who owns the bus, and it starts counting again as soon as reset is released. Expiries missed during long holds are kept in a pending count, which is served later and reported as overdue when it grows too large. The interval reload is a parameter. The designer chooses it as the 2 ms row budget divided by the row count, minus the worst-case hold-to-acknowledge latency, which gives for example 75 cycles at 5 MHz.

Top module: `refresh_hold_arbiter`

## Requirements
- R1: The interval timer counts down from INTERVAL-1 after reset release and expires every INTERVAL cycles in distributed mode. It runs whatever the bus state is, and each expiry adds one pending refresh.
- R2: When burst_mode is high at a timer reload, the next period lasts BURST_PERIOD cycles. Its expiry adds ROWS pending refreshes, and these are served back to back under one hold while pending is non-zero.
- R3: rfsh_strobe is a single-cycle pulse. It rises the cycle after hold_ack is sampled high while a refresh hold is waiting. Each strobe retires one pending refresh, and no two strobes fall in adjacent cycles.
- R4: rfsh_row is 0 after reset and advances by one in the cycle after each strobe. It wraps from 127 to 0.
- R5: After a strobe with no further burst work, hold_req stays high for one more cycle and then drops. No new hold is raised until hold_ack has been sampled low.
- R6: dma_grant rises the cycle after hold_ack is sampled high during a DMA hold. Grant and hold drop the cycle after dma_req is sampled low. A DMA hold whose request is withdrawn before the acknowledge is released without a grant.
- R7: While DMA holds the bus, grant and hold drop in the cycle after rfsh_overdue is sampled high.
- R8: When refresh is pending and dma_req is high while the arbiter is idle, the side not served last wins. Refresh wins first after reset.
- R9: rfsh_overdue is high when the pending count exceeds 1 in a distributed period, or exceeds ROWS in a burst period.
- R10: Reset clears hold_req, dma_grant, rfsh_strobe, rfsh_overdue, the pending count and rfsh_row to 0, and the arbiter returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | processor clock |
| rst_n | input | 1 | asynchronous active-low reset |
| burst_mode | input | 1 | selects burst refresh at the next timer reload |
| dma_req | input | 1 | bus request from the DMA controller |
| hold_ack | input | 1 | hold acknowledge from the processor |
| hold_req | output | 1 | hold request to the processor |
| dma_grant | output | 1 | bus grant to the DMA controller |
| rfsh_strobe | output | 1 | one-cycle refresh cycle strobe |
| rfsh_row | output | ROW_BITS | row address of the current refresh |
| rfsh_overdue | output | 1 | more refreshes outstanding than the mode allows |

## Verification
Every output is registered state or decoded from it. A timer expiry therefore shows in the pending count one clock later, and in the hold request one clock after that. A strobe follows the sampled acknowledge by one clock, the row advances one clock after the strobe, and hold falls two clocks after a final strobe. Grant rises or falls one clock after the acknowledge, dma_req or overdue is sampled. The bench drives its inputs and its emulated processor acknowledge on the falling edge. A behavioural model steps on each rising edge, and every output is compared against the model on the following falling edge, so each result is checked in exactly the cycle it is due. Targeted checks of reset, row wrap, starvation under a DMA hog and burst length sit on top of this comparison.

// File: rtl/rha_pkg.sv
package rha_pkg;
   typedef enum logic [2:0] {
      ARB_IDLE   = 3'd0,
      ARB_RF_WT  = 3'd1,
      ARB_RF_STB = 3'd2,
      ARB_RF_TL  = 3'd3,
      ARB_REL    = 3'd4,
      ARB_DMA_WT = 3'd5,
      ARB_DMA_ON = 3'd6
   } arb_state_t;
endpackage

// File: rtl/rha_interval_timer.sv
module rha_interval_timer #(
   parameter int INTERVAL     = 75,
   parameter int BURST_PERIOD = 10000,
   parameter bit BURST_EN     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic burst_mode,
   output logic tick,
   output logic period_burst
);
   localparam int MAXPER = (BURST_PERIOD > INTERVAL) ? BURST_PERIOD : INTERVAL;
   localparam int CW     = $clog2(MAXPER);

   logic [CW-1:0] cnt_q;
   logic          burst_q;
   logic          burst_sel;

   generate
      if (BURST_EN) begin : g_burst
         assign burst_sel = burst_mode;
      end else begin : g_dist_only
         logic unused_mode;
         assign unused_mode = burst_mode;
         assign burst_sel   = 1'b0;
      end
   endgenerate

   assign tick         = (cnt_q == '0);
   assign period_burst = burst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= CW'(INTERVAL - 1);
         burst_q <= 1'b0;
      end else if (tick) begin
         burst_q <= burst_sel;
         cnt_q   <= burst_sel ? CW'(BURST_PERIOD - 1) : CW'(INTERVAL - 1);
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/rha_refresh_queue.sv
module rha_refresh_queue #(
   parameter int ROW_BITS = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                period_burst,
   input  logic                strobe,
   output logic                pend_nz,
   output logic                overdue,
   output logic [ROW_BITS-1:0] row
);
   localparam int ROWS = 1 << ROW_BITS;
   localparam int PW   = $clog2(2 * ROWS + 1);
   localparam logic [PW:0] PMAX = {1'b0, {PW{1'b1}}};

   logic [PW-1:0]       pend_q;
   logic [PW:0]         add_amt;
   logic [PW:0]         sum;
   logic [ROW_BITS-1:0] row_q;

   always_comb begin
      add_amt = '0;
      if (tick) add_amt = period_burst ? (PW+1)'(ROWS) : (PW+1)'(1);
      sum = {1'b0, pend_q} + add_amt - {{PW{1'b0}}, strobe};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         row_q  <= '0;
      end else begin
         pend_q <= (sum > PMAX) ? PMAX[PW-1:0] : sum[PW-1:0];
         if (strobe) row_q <= row_q + 1'b1;
      end
   end

   assign pend_nz = (pend_q != '0);
   assign overdue = period_burst ? (pend_q > PW'(ROWS)) : (pend_q > PW'(1));
   assign row     = row_q;
endmodule

// File: rtl/rha_arbiter_fsm.sv
module rha_arbiter_fsm
   import rha_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pend_nz,
   input  logic overdue,
   input  logic period_burst,
   input  logic dma_req,
   input  logic hold_ack,
   output logic hold_req,
   output logic dma_grant,
   output logic strobe
);
   arb_state_t st_q, st_d;
   logic       last_dma_q, last_dma_d;

   always_comb begin
      st_d       = st_q;
      last_dma_d = last_dma_q;
      unique case (st_q)
         ARB_IDLE: begin
            if (pend_nz && (!dma_req || last_dma_q)) begin
               st_d       = ARB_RF_WT;
               last_dma_d = 1'b0;
            end else if (dma_req) begin
               st_d       = ARB_DMA_WT;
               last_dma_d = 1'b1;
            end
         end
         ARB_RF_WT:  if (hold_ack) st_d = ARB_RF_STB;
         ARB_RF_STB: st_d = ARB_RF_TL;
         ARB_RF_TL:  st_d = (period_burst && pend_nz) ? ARB_RF_STB : ARB_REL;
         ARB_REL:    if (!hold_ack) st_d = ARB_IDLE;
         ARB_DMA_WT: begin
            if (!dma_req)      st_d = ARB_REL;
            else if (hold_ack) st_d = ARB_DMA_ON;
         end
         ARB_DMA_ON: if (!dma_req || overdue) st_d = ARB_REL;
         default:    st_d = ARB_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ARB_IDLE;
         last_dma_q <= 1'b1;
      end else begin
         st_q       <= st_d;
         last_dma_q <= last_dma_d;
      end
   end

   assign hold_req  = (st_q == ARB_RF_WT) || (st_q == ARB_RF_STB) || (st_q == ARB_RF_TL) ||
                      (st_q == ARB_DMA_WT) || (st_q == ARB_DMA_ON);
   assign dma_grant = (st_q == ARB_DMA_ON);
   assign strobe    = (st_q == ARB_RF_STB);
endmodule

// File: rtl/refresh_hold_arbiter.sv
module refresh_hold_arbiter #(
   parameter int ROW_BITS     = 7,
   parameter int INTERVAL     = 75,
   parameter int BURST_PERIOD = 10000,
   parameter bit BURST_EN     = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                burst_mode,
   input  logic                dma_req,
   input  logic                hold_ack,
   output logic                hold_req,
   output logic                dma_grant,
   output logic                rfsh_strobe,
   output logic [ROW_BITS-1:0] rfsh_row,
   output logic                rfsh_overdue
);
   localparam int ROWS = 1 << ROW_BITS;

   generate
      if (ROW_BITS < 1 || ROW_BITS > 12) begin : g_bad_rows
         $error("ROW_BITS out of range");
      end
      if (INTERVAL < 4) begin : g_bad_interval
         $error("INTERVAL must allow a full hold handshake");
      end
      if (BURST_EN && (BURST_PERIOD < 3 * ROWS)) begin : g_bad_burst
         $error("BURST_PERIOD too short for a full burst");
      end
   endgenerate

   logic tick, period_burst, pend_nz;

   rha_interval_timer #(
      .INTERVAL(INTERVAL), .BURST_PERIOD(BURST_PERIOD), .BURST_EN(BURST_EN)
   ) i_timer (
      .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode),
      .tick(tick), .period_burst(period_burst)
   );

   rha_refresh_queue #(.ROW_BITS(ROW_BITS)) i_queue (
      .clk(clk), .rst_n(rst_n), .tick(tick), .period_burst(period_burst),
      .strobe(rfsh_strobe), .pend_nz(pend_nz), .overdue(rfsh_overdue),
      .row(rfsh_row)
   );

   rha_arbiter_fsm i_fsm (
      .clk(clk), .rst_n(rst_n), .pend_nz(pend_nz), .overdue(rfsh_overdue),
      .period_burst(period_burst), .dma_req(dma_req), .hold_ack(hold_ack),
      .hold_req(hold_req), .dma_grant(dma_grant), .strobe(rfsh_strobe)
   );
endmodule

// File: rtl/rha_checker.sv
module rha_checker #(
   parameter int ROW_BITS = 7
) (
   input logic                clk,
   input logic                rst_n,
   input logic                dma_req,
   input logic                hold_ack,
   input logic                hold_req,
   input logic                dma_grant,
   input logic                rfsh_strobe,
   input logic [ROW_BITS-1:0] rfsh_row,
   input logic                rfsh_overdue
);
   // R3: strobe only under hold, never in adjacent cycles
   a_r3_strobe_under_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_strobe |-> hold_req && !dma_grant);
   a_r3_strobe_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_strobe |=> !rfsh_strobe);
   // R4: row steps by one after a strobe, holds otherwise
   a_r4_row_step: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_strobe |=> rfsh_row == ROW_BITS'($past(rfsh_row) + 1'b1));
   a_r4_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rfsh_strobe |=> $stable(rfsh_row));
   // R5: hold still high in the cycle after a strobe
   a_r5_tail: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_strobe |=> hold_req);
   // R6: grant follows a sampled acknowledge and a live request
   a_r6_grant_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_grant) |-> $past(hold_ack) && $past(dma_req));
   a_r6_grant_drop: assert property (@(posedge clk) disable iff (!rst_n)
      dma_grant && !dma_req |=> !dma_grant);
   // R7: overdue refresh preempts DMA
   a_r7_preempt: assert property (@(posedge clk) disable iff (!rst_n)
      dma_grant && rfsh_overdue |=> !dma_grant && !hold_req);
endmodule

bind refresh_hold_arbiter rha_checker #(.ROW_BITS(ROW_BITS)) i_rha_checker (
   .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .hold_ack(hold_ack),
   .hold_req(hold_req), .dma_grant(dma_grant), .rfsh_strobe(rfsh_strobe),
   .rfsh_row(rfsh_row), .rfsh_overdue(rfsh_overdue)
);

// File: tb/test_refresh_hold_arbiter.sv
`timescale 1ns/1ps
module test_refresh_hold_arbiter;
   localparam int RB    = 7;
   localparam int ROWS  = 1 << RB;
   localparam int IVL   = 75;
   localparam int BPER  = 1000;
   localparam int LAT   = 3;
   localparam int PMAXV = 511;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic burst_mode = 1'b0;
   logic dma_req = 1'b0;
   logic hold_ack = 1'b0;
   logic hold_req, dma_grant, rfsh_strobe, rfsh_overdue;
   logic [RB-1:0] rfsh_row;

   always #4 clk = ~clk;

   refresh_hold_arbiter #(.ROW_BITS(RB), .INTERVAL(IVL), .BURST_PERIOD(BPER), .BURST_EN(1'b1))
   i_refresh_hold_arbiter (
      .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .dma_req(dma_req),
      .hold_ack(hold_ack), .hold_req(hold_req), .dma_grant(dma_grant),
      .rfsh_strobe(rfsh_strobe), .rfsh_row(rfsh_row), .rfsh_overdue(rfsh_overdue)
   );

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit cmp_en = 0;
   int strobes = 0;
   int max_run = 0;
   int run = 0;
   int overdue_seen = 0;

   // behavioural reference model: phases 0 idle,1 rf wait,2 strobe,3 tail,4 release,5 dma wait,6 dma on
   int  m_ph = 0;
   bit  m_last_dma = 1;
   int  m_pend = 0;
   int  m_row = 0;
   int  m_cnt = IVL - 1;
   bit  m_burst = 0;

   function automatic bit m_overdue();
      return m_burst ? (m_pend > ROWS) : (m_pend > 1);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_last_dma = 1; m_pend = 0; m_row = 0; m_cnt = IVL - 1; m_burst = 0;
      end else begin
         int  nph;
         bit  stb, tk, od;
         stb = (m_ph == 2);
         tk  = (m_cnt == 0);
         od  = m_overdue();
         nph = m_ph;
         case (m_ph)
            0: if (m_pend > 0 && (!dma_req || m_last_dma)) begin nph = 1; m_last_dma = 0; end
               else if (dma_req) begin nph = 5; m_last_dma = 1; end
            1: if (hold_ack) nph = 2;
            2: nph = 3;
            3: nph = (m_burst && m_pend > 0) ? 2 : 4;
            4: if (!hold_ack) nph = 0;
            5: if (!dma_req) nph = 4; else if (hold_ack) nph = 6;
            6: if (!dma_req || od) nph = 4;
            default: nph = 0;
         endcase
         m_pend = m_pend + (tk ? (m_burst ? ROWS : 1) : 0) - (stb ? 1 : 0);
         if (m_pend > PMAXV) m_pend = PMAXV;
         if (stb) m_row = (m_row + 1) % ROWS;
         if (tk) begin
            m_burst = burst_mode;
            m_cnt   = burst_mode ? BPER - 1 : IVL - 1;
         end else m_cnt = m_cnt - 1;
         m_ph = nph;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
      end
   endtask

   // emulated processor acknowledge, per-cycle comparison, bookkeeping
   int hcnt = 0;
   always @(negedge clk) begin
      cycles++;
      if (cmp_en) begin
         bit e_hold;
         e_hold = (m_ph == 1 || m_ph == 2 || m_ph == 3 || m_ph == 5 || m_ph == 6);
         chk(hold_req == e_hold, "R5 hold_req", int'(hold_req), int'(e_hold));
         chk(dma_grant == (m_ph == 6), "R6 dma_grant", int'(dma_grant), int'(m_ph == 6));
         chk(rfsh_strobe == (m_ph == 2), "R3 rfsh_strobe", int'(rfsh_strobe), int'(m_ph == 2));
         chk(int'(rfsh_row) == m_row, "R4 rfsh_row", int'(rfsh_row), m_row);
         chk(rfsh_overdue == m_overdue(), "R9 rfsh_overdue", int'(rfsh_overdue), int'(m_overdue()));
      end
      if (rfsh_strobe) strobes++;
      if (rfsh_strobe) run++;
      else if (!hold_req) begin if (run > max_run) max_run = run; run = 0; end
      if (rfsh_overdue) overdue_seen++;
      if (hold_req) hcnt++; else hcnt = 0;
      hold_ack = (hcnt >= LAT);
   end

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic sample_point();
      @(posedge clk); #2;
   endtask

   initial begin : watchdog
      wait (cycles > 150000);
      bad++; total++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int s0;
      // R10: reset state
      wait_cyc(3);
      chk(!hold_req && !dma_grant && !rfsh_strobe && !rfsh_overdue && rfsh_row == '0,
          "R10 reset outputs", int'({hold_req, dma_grant, rfsh_strobe, rfsh_overdue}), 0);
      rst_n = 1'b1;
      cmp_en = 1;
      strobes = 0;

      // R1: first refresh after one interval
      wait_cyc(IVL + LAT + 4);
      sample_point();
      chk(strobes == 1, "R1 first refresh after reset", strobes, 1);

      // R4: run past one full row wrap with an idle bus
      wait_cyc(ROWS * IVL + 200);
      sample_point();
      chk(int'(rfsh_row) == strobes % ROWS, "R4 row wrap", int'(rfsh_row), strobes % ROWS);
      chk(strobes > ROWS, "R4 more strobes than rows", strobes, ROWS + 1);

      // R6/R8: short DMA bursts interleaved with refresh
      for (int k = 0; k < 40; k++) begin
         @(negedge clk) dma_req = 1'b1;
         wait_cyc(15 + (k % 7) * 9);
         @(negedge clk) dma_req = 1'b0;
         wait_cyc(3 + (k % 5) * 11);
      end
      // R6: request withdrawn before acknowledge
      wait_cyc(20);
      @(negedge clk) dma_req = 1'b1;
      @(negedge clk) dma_req = 1'b0;
      wait_cyc(10);

      // R7/R9: DMA hog, refresh must still be served
      s0 = strobes;
      overdue_seen = 0;
      @(negedge clk) dma_req = 1'b1;
      wait_cyc(40 * IVL);
      sample_point();
      chk(strobes - s0 >= 38, "R7 refresh served under DMA hog", strobes - s0, 38);
      chk(overdue_seen > 0, "R9 overdue raised under hog", overdue_seen, 1);
      @(negedge clk) dma_req = 1'b0;
      wait_cyc(200);

      // R2: burst mode, one long run of strobes
      max_run = 0;
      @(negedge clk) burst_mode = 1'b1;
      wait_cyc(IVL + BPER + 2 * ROWS + 100);
      sample_point();
      chk(max_run >= ROWS, "R2 burst run length", max_run, ROWS);
      // R2 with DMA competing in burst mode
      @(negedge clk) dma_req = 1'b1;
      wait_cyc(BPER + 300);
      @(negedge clk) dma_req = 1'b0;
      @(negedge clk) burst_mode = 1'b0;
      wait_cyc(BPER + 300);

      // R10: mid-run reset, then R1 restart of the timer
      @(negedge clk) rst_n = 1'b0;
      cmp_en = 0;
      wait_cyc(2);
      sample_point();
      chk(!hold_req && !dma_grant && !rfsh_overdue && rfsh_row == '0,
          "R10 mid-run reset", int'({hold_req, dma_grant, rfsh_overdue}), 0);
      @(negedge clk) rst_n = 1'b1;
      cmp_en = 1;
      strobes = 0;
      wait_cyc(IVL - 2);
      sample_point();
      chk(strobes == 0, "R1 no refresh before interval", strobes, 0);
      wait_cyc(LAT + 8);
      sample_point();
      chk(strobes == 1, "R1 refresh one interval after reset", strobes, 1);

      // R8: refresh wins first tie after reset
      @(negedge clk) dma_req = 1'b1;
      wait_cyc(3 * IVL);
      @(negedge clk) dma_req = 1'b0;
      wait_cyc(50);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule